// File: doc/BRIEF.md
# Dual-Read Program Register File

This block holds the general-purpose registers of a small processor. It has two read ports and one write port, and all three work in the same cycle. Each read port takes a register identifier and returns that register's word at once, with no clock in the path. The write port takes a destination identifier and a word, and the word is stored on the rising clock edge.

Identifiers are wider than the register count needs. Any identifier at or above the register count is a null code. On a read port a null code returns zero. On the write port a null code leaves every register untouched. A decode stage or an execute stage can therefore switch a port off by presenting a null code, and it needs no separate enable pin.

A read of the register that is being written in the same cycle returns the stored value from before the edge. There is no forwarding inside the block. A synchronous reset clears every register.

Top module: `prog_regfile`

## Requirements
- R1: Both read ports and the write port operate in the same cycle, and each read port follows only its own identifier.
- R2: Identifiers 0 to NUM_REGS-1 (0 to 7 by default) select a register. A read with such an identifier returns the full DATA_W-bit word (32 bits by default) stored in that register.
- R3: A write takes effect on the rising clock edge. A read of the written register in the same cycle returns the old word, and the new word can be read after the edge.
- R4: A read identifier at or above NUM_REGS (8 to 15 with the 4-bit default identifier) returns all zeros.
- R5: A write identifier at or above NUM_REGS (8 to 15 by default) changes no register.
- R6: When rst is high at a rising edge, every register is cleared to zero. Reset takes priority over a write in the same cycle.
- R7: Both read ports may name the same register at once, and both then return that register's word.
- R8: A write changes only the register it names, and every other register keeps its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_id | input | ID_W | Identifier for read port A |
| rd_a_data | output | DATA_W | Word returned on read port A |
| rd_b_id | input | ID_W | Identifier for read port B |
| rd_b_data | output | DATA_W | Word returned on read port B |
| wr_id | input | ID_W | Destination identifier for the write port |
| wr_data | input | DATA_W | Word to be written |

## Verification
The bench builds the block with its default parameters: 32-bit words, 4-bit identifiers and eight registers. With these values the upper half of the identifier space is made of null codes, so the bench can drive every null code from 8 to 15 on both read ports and on the write port, and show that each one reads as zero or stores nothing. The register count is small, so every register can be written with its own pattern and read back on both ports. The bench also covers a same-cycle write and read of one register, and a reset that arrives together with a write.

// File: rtl/prog_rf_pkg.sv
package prog_rf_pkg;
  // Default geometry of the register file
  localparam int RF_DATA_W   = 32;
  localparam int RF_ID_W     = 4;
  localparam int RF_NUM_REGS = 8;

  // Extract one word from a flattened register image
  function automatic logic [RF_DATA_W-1:0] rf_word_of(
    input logic [RF_NUM_REGS*RF_DATA_W-1:0] img,
    input int unsigned idx
  );
    return img[idx*RF_DATA_W +: RF_DATA_W];
  endfunction
endpackage

// File: rtl/prog_rf_id_decode.sv
module prog_rf_id_decode #(
  parameter int ID_W     = 4,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ID_W-1:0]     id,
  output logic                live,
  output logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] sel
);
  localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_REGS);

  // Identifiers at or above the register count are null codes
  assign live = ({1'b0, id} < LIMIT);
  assign idx  = id[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel[g] = live && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/prog_rf_storage.sv
module prog_rf_storage #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_REGS-1:0]          wr_sel,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NUM_REGS*DATA_W-1:0]   q_flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)            word_q <= '0;
      else if (wr_sel[g]) word_q <= wr_data;
    end
    assign q_flat[g*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/prog_rf_read_port.sv
module prog_rf_read_port #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS*DATA_W-1:0] q_flat,
  input  logic                       live,
  input  logic [IDX_W-1:0]           idx,
  output logic [DATA_W-1:0]          data
);
  always_comb begin
    data = '0;
    if (live) data = q_flat[idx*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/prog_regfile.sv
module prog_regfile
  import prog_rf_pkg::*;
#(
  parameter int DATA_W   = RF_DATA_W,
  parameter int ID_W     = RF_ID_W,
  parameter int NUM_REGS = RF_NUM_REGS,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int RD_PORTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   rd_a_id,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ID_W-1:0]   rd_b_id,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DATA_W-1:0] wr_data
);
  // Named internal events, brought out for the checker
  logic                       wr_fire;
  logic [IDX_W-1:0]           wr_idx;
  logic [NUM_REGS-1:0]        wr_sel;
  logic [NUM_REGS*DATA_W-1:0] q_flat;

  logic [ID_W-1:0]   rd_id   [RD_PORTS];
  logic              rd_live [RD_PORTS];
  logic [IDX_W-1:0]  rd_idx  [RD_PORTS];
  logic [DATA_W-1:0] rd_word [RD_PORTS];

  assign rd_id[0] = rd_a_id;
  assign rd_id[1] = rd_b_id;

  prog_rf_id_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_wr_dec (
    .id(wr_id), .live(wr_fire), .idx(wr_idx), .sel(wr_sel)
  );

  prog_rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wr_data(wr_data), .q_flat(q_flat)
  );

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [NUM_REGS-1:0] sel_unused;
    prog_rf_id_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_dec (
      .id(rd_id[p]), .live(rd_live[p]), .idx(rd_idx[p]), .sel(sel_unused)
    );
    prog_rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_port (
      .q_flat(q_flat), .live(rd_live[p]), .idx(rd_idx[p]), .data(rd_word[p])
    );
  end

  assign rd_a_data = rd_word[0];
  assign rd_b_data = rd_word[1];
endmodule

// File: rtl/prog_rf_checker.sv
module prog_rf_checker
  import prog_rf_pkg::*;
#(
  parameter int DATA_W   = RF_DATA_W,
  parameter int NUM_REGS = RF_NUM_REGS,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_fire,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [DATA_W-1:0]          wr_data,
  input logic [NUM_REGS-1:0]        wr_sel,
  input logic [NUM_REGS*DATA_W-1:0] q_flat,
  input logic                       rd_a_live,
  input logic [IDX_W-1:0]           rd_a_idx,
  input logic [DATA_W-1:0]          rd_a_data,
  input logic                       rd_b_live,
  input logic [IDX_W-1:0]           rd_b_idx,
  input logic [DATA_W-1:0]          rd_b_data
);
  function automatic logic [DATA_W-1:0] word_at(input logic [NUM_REGS*DATA_W-1:0] img,
                                                input logic [IDX_W-1:0] i);
    return img[i*DATA_W +: DATA_W];
  endfunction

  // R3: a write stores its word at the next edge
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_fire) |=> word_at(q_flat, $past(wr_idx)) == $past(wr_data));

  // R5: no write, no change
  assert_null_write_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr_fire) |=> $stable(q_flat));

  // R8: at most one register is selected for writing
  assert_single_target_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

  // R4: null read codes give zero
  assert_null_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!rd_a_live || !rd_b_live) |->
      ((rd_a_live || rd_a_data == '0) && (rd_b_live || rd_b_data == '0)));

  // R2: live reads return the stored word
  assert_read_matches_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_a_live |-> rd_a_data == word_at(q_flat, rd_a_idx)) and
    (rd_b_live |-> rd_b_data == word_at(q_flat, rd_b_idx)));

  // R6: one edge with reset held leaves every register clear
  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst_seen_q) assert_reset_clears_R6: assert (q_flat == '0);
  end
endmodule

bind prog_regfile prog_rf_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_checker (
  .clk(clk), .rst(rst),
  .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data), .wr_sel(wr_sel),
  .q_flat(q_flat),
  .rd_a_live(rd_live[0]), .rd_a_idx(rd_idx[0]), .rd_a_data(rd_a_data),
  .rd_b_live(rd_live[1]), .rd_b_idx(rd_idx[1]), .rd_b_data(rd_b_data)
);

// File: tb/test_prog_regfile.sv
module test_prog_regfile;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam int NR = 8;
  localparam logic [IW-1:0] NULL_ID = IW'(8);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic [IW-1:0] ra, rb, wi;
  logic [DW-1:0] wd;
  logic [DW-1:0] da, db;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] model [NR];

  prog_regfile i_prog_regfile (
    .clk(clk), .rst(rst),
    .rd_a_id(ra), .rd_a_data(da),
    .rd_b_id(rb), .rd_b_data(db),
    .wr_id(wi), .wr_data(wd)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Advance one clock: after return we sit at a falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int a, input int b);
    ra = IW'(a);
    rb = IW'(b);
    #2;
  endtask

  function automatic logic [DW-1:0] expect_of(input int id);
    return (id < NR) ? model[id] : '0;
  endfunction

  task automatic wr(input int id, input logic [DW-1:0] d);
    wi = IW'(id);
    wd = d;
    cyc();
    if (id < NR) model[id] = d;
    wi = NULL_ID;
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NR; i++) begin
      rd(i, NR - 1 - i);
      chk(tag, da, model[i]);
      chk(tag, db, model[NR - 1 - i]);
    end
  endtask

  task automatic t_initial_reset();
    rst = 1'b1;
    cyc();
    cyc();
    rst = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    check_all("R6 initial reset clears");
  endtask

  task automatic t_fill_and_read();
    for (int i = 0; i < NR; i++) wr(i, 32'hC3A50000 ^ (32'h01010101 * (i + 1)));
    check_all("R2 read back per register");
  endtask

  task automatic t_same_cycle();
    rd(3, 3);
    wi = IW'(3);
    wd = 32'h12345678;
    #1;
    chk("R3 same-cycle read gives old A", da, model[3]);
    chk("R3 same-cycle read gives old B", db, model[3]);
    cyc();
    model[3] = 32'h12345678;
    wi = NULL_ID;
    #2;
    chk("R3 new word after edge", da, 32'h12345678);
  endtask

  task automatic t_null_read();
    for (int i = NR; i < (1 << IW); i++) begin
      rd(i, (1 << IW) - 1 - (i - NR));
      chk("R4 null read A", da, '0);
      chk("R4 null read B", db, '0);
    end
  endtask

  task automatic t_null_write();
    for (int i = NR; i < (1 << IW); i++) wr(i, 32'hDEAD0000 | 32'(i));
    check_all("R5 null write leaves registers");
  endtask

  task automatic t_concurrent();
    // read 1 and 6 while writing 4
    rd(1, 6);
    wi = IW'(4);
    wd = 32'h0BADF00D;
    #1;
    chk("R1 port A independent", da, model[1]);
    chk("R1 port B independent", db, model[6]);
    cyc();
    model[4] = 32'h0BADF00D;
    wi = NULL_ID;
    rd(4, 2);
    chk("R1 written reg on A", da, 32'h0BADF00D);
    chk("R1 port B other reg", db, model[2]);
    rd(5, 5);
    chk("R7 same reg on A", da, model[5]);
    chk("R7 same reg on B", db, model[5]);
    rd(2, 12);
    chk("R1 live A with null B", da, model[2]);
    chk("R4 null B beside live A", db, expect_of(12));
  endtask

  task automatic t_isolation();
    wr(5, 32'hFFFFFFFF);
    wr(0, 32'h00000001);
    check_all("R8 other registers untouched");
  endtask

  task automatic t_reset_over_write();
    rst = 1'b1;
    wi = IW'(2);
    wd = 32'hAAAA5555;
    cyc();
    rst = 1'b0;
    wi = NULL_ID;
    for (int i = 0; i < NR; i++) model[i] = '0;
    check_all("R6 reset beats write");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    rst = 1'b1;
    ra = '0;
    rb = '0;
    wi = NULL_ID;
    wd = '0;
    @(negedge clk);
    t_initial_reset();
    t_fill_and_read();
    t_same_cycle();
    t_null_read();
    t_null_write();
    t_concurrent();
    t_isolation();
    t_reset_over_write();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule